// File: doc/BRIEF.md
# DMA Request Handshake Arbiter

This block sits between a pool of peripheral request lines and the channels of a DMA engine. Each channel carries an enable and a 3-bit select field. The select field picks one of that channel's fixed request inputs from a shared physical request vector. A neighbouring channel can reach the same physical line through its own select field, so one peripheral request may be wired to two channels.

Each enabled channel runs a four-phase request/acknowledge handshake with its selected peripheral. When the shared bus is idle and no grant is outstanding, the block picks the highest-priority pending channel. It then raises the grant and issues a single one-cycle access command for that channel, and asserts the channel's acknowledge. The grant is held until the bus side reports completion through a transfer-done pulse. The acknowledge is held until the peripheral withdraws its request, which closes the handshake.

Two enabled channels that select the same physical line form an illegal setup. The block flags both channels and serves only the lower-numbered one.

Top module: `dma_hs_arbiter_top`

## Requirements
- R1: Channel c with select value s reads physical line `req_i[(c*STRIDE + s) % NUM_PERIPH]`. The select field of channel c sits at bits `ch_sel_i[c*SEL_W +: SEL_W]`.
- R2: A new grant is taken only at a clock edge where `bus_idle_i` is high, `gnt_o` is low and some channel is pending. After that edge, `gnt_o` is 1, `gnt_ch_o` holds the channel index and that channel's `ack_o` bit is 1. `cmd_o` is high for exactly that one cycle.
- R3: Priority is fixed. Among pending channels, the lowest index wins.
- R4: Once asserted, a channel's acknowledge stays high while its selected request is high. It clears at the first clock edge that samples the request low.
- R5: A channel whose acknowledge is high is not granted again. After its acknowledge clears, a new request on that channel makes it eligible again.
- R6: `gnt_o` and `gnt_ch_o` hold until an edge samples `xfer_done_i` high, and `gnt_o` clears at that edge. A pulse on `xfer_done_i` while `gnt_o` is low has no effect.
- R7: A channel whose enable is low ignores its request and never raises its acknowledge.
- R8: A channel disabled mid-handshake keeps its acknowledge until its request drops, then returns to idle. It does not respond to later requests while it stays disabled.
- R9: `conflict_o[c]` is high, combinationally, exactly when channel c is enabled and another enabled channel maps to the same physical line.
- R10: Among conflicting channels, only the lowest-numbered one is served. A higher-numbered channel becomes servable once the lower one is disabled.
- R11: After reset, `ack_o`, `gnt_o`, `gnt_ch_o` and `cmd_o` are all zero.
- R12: At most one acknowledge bit rises per clock edge, and a rising acknowledge always coincides with `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PERIPH | Physical peripheral request lines |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_sel_i | input | NUM_CH*SEL_W | Per-channel request select fields, packed |
| bus_idle_i | input | 1 | Shared bus can accept a new access |
| xfer_done_i | input | 1 | Pulse ending the granted transfer |
| ack_o | output | NUM_CH | Per-channel handshake acknowledge, registered |
| gnt_o | output | 1 | A channel holds the bus |
| gnt_ch_o | output | $clog2(NUM_CH) | Index of the granted channel |
| cmd_o | output | 1 | One-cycle bus access command |
| conflict_o | output | NUM_CH | Channel shares its physical line with another enabled channel |

## Verification
The bench builds the block with its default parameters: 8 channels, 3-bit selects, 16 physical lines and a stride of 5. With these values, the physical ranges of neighbouring channels overlap. For example, channel 0 with select 5 and channel 1 with select 0 both land on line 5, which puts shared-line conflicts and their tie-break within reach. The same values also let two channels sit on distinct lines, so priority and re-grant ordering can be driven together.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_e;
endpackage

// File: rtl/dma_hs_router.sv
module dma_hs_router #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned NUM_PERIPH = 16,
  parameter int unsigned STRIDE     = 5
) (
  input  logic [NUM_PERIPH-1:0]   req_i,
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  output logic [NUM_CH-1:0]       ch_req_o,
  output logic [NUM_CH-1:0]       conflict_o,
  output logic [NUM_CH-1:0]       shadowed_o
);
  localparam int unsigned PIDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic [PIDX_W-1:0] phys [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    localparam int unsigned BASE = (c * STRIDE) % NUM_PERIPH;
    logic [31:0] sum;
    assign sum         = BASE + 32'(sel_i[c*SEL_W +: SEL_W]);
    assign phys[c]     = PIDX_W'(sum % NUM_PERIPH);
    assign ch_req_o[c] = req_i[phys[c]];
  end

  // shadowed: a lower-numbered enabled channel owns the same line
  always_comb begin
    conflict_o = '0;
    shadowed_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      for (int j = 0; j < NUM_CH; j++) begin
        if (i != j && en_i[i] && en_i[j] && phys[i] == phys[j]) begin
          conflict_o[i] = 1'b1;
          if (j < i) shadowed_o[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_hs_channel.sv
module dma_hs_channel
  import dma_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic grant_i,
  output logic ack_o,
  output logic idle_o
);
  hs_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE: if (grant_i) state_q <= HS_ACK;
        HS_ACK:  if (!req_i)  state_q <= HS_IDLE;
        default:              state_q <= HS_IDLE;
      endcase
    end
  end

  assign ack_o  = (state_q == HS_ACK);
  assign idle_o = (state_q == HS_IDLE);
endmodule

// File: rtl/dma_hs_arbiter.sv
module dma_hs_arbiter #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic              bus_idle_i,
  input  logic              done_i,
  output logic              gnt_o,
  output logic [CH_W-1:0]   gnt_ch_o,
  output logic              cmd_o,
  output logic [NUM_CH-1:0] win_o
);
  logic            gnt_q, cmd_q, start;
  logic [CH_W-1:0] ch_q, win_idx;

  // downward scan: lowest pending index is assigned last
  always_comb begin
    win_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) win_idx = CH_W'(i);
    end
  end

  assign start = bus_idle_i && !gnt_q && (|pend_i);
  assign win_o = start ? (NUM_CH'(1) << win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= 1'b0;
      ch_q  <= '0;
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= start;
      if (start) begin
        gnt_q <= 1'b1;
        ch_q  <= win_idx;
      end else if (done_i) begin
        gnt_q <= 1'b0;
      end
    end
  end

  assign gnt_o    = gnt_q;
  assign gnt_ch_o = ch_q;
  assign cmd_o    = cmd_q;
endmodule

// File: rtl/dma_hs_arbiter_top.sv
module dma_hs_arbiter_top #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned NUM_PERIPH = 16,
  parameter int unsigned STRIDE     = 5,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_PERIPH-1:0]   req_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel_i,
  input  logic                    bus_idle_i,
  input  logic                    xfer_done_i,
  output logic [NUM_CH-1:0]       ack_o,
  output logic                    gnt_o,
  output logic [CH_W-1:0]         gnt_ch_o,
  output logic                    cmd_o,
  output logic [NUM_CH-1:0]       conflict_o
);
  logic [NUM_CH-1:0] ch_req, shadowed, idle, pend, win;

  dma_hs_router #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .NUM_PERIPH(NUM_PERIPH), .STRIDE(STRIDE)
  ) i_router (
    .req_i      (req_i),
    .en_i       (ch_en_i),
    .sel_i      (ch_sel_i),
    .ch_req_o   (ch_req),
    .conflict_o (conflict_o),
    .shadowed_o (shadowed)
  );

  assign pend = ch_en_i & ch_req & ~shadowed & idle;

  dma_hs_arbiter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .bus_idle_i (bus_idle_i),
    .done_i     (xfer_done_i),
    .gnt_o      (gnt_o),
    .gnt_ch_o   (gnt_ch_o),
    .cmd_o      (cmd_o),
    .win_o      (win)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_hs_channel i_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (ch_req[c]),
      .grant_i (win[c]),
      .ack_o   (ack_o[c]),
      .idle_o  (idle[c])
    );
  end
endmodule

// File: rtl/dma_hs_checker.sv
module dma_hs_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic              bus_idle_i,
  input logic              xfer_done_i,
  input logic [NUM_CH-1:0] ack_o,
  input logic              gnt_o,
  input logic [CH_W-1:0]   gnt_ch_o,
  input logic              cmd_o
);
  a_r2_cmd_in_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> gnt_o);
  a_r2_grant_rise_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_o) |-> cmd_o);
  a_r2_cmd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |=> !cmd_o);
  a_r2_busy_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_idle_i |=> !cmd_o);
  a_r6_grant_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !xfer_done_i) |=> (gnt_o && $stable(gnt_ch_o)));
  a_r6_grant_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && xfer_done_i) |=> !gnt_o);
  a_r12_one_new_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ack_o & ~$past(ack_o)) <= 1);
  a_r12_new_ack_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_o & ~$past(ack_o))) |-> cmd_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_en_i[c] && !ack_o[c]) |=> !ack_o[c]);
  end
endmodule

bind dma_hs_arbiter_top dma_hs_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_en_i     (ch_en_i),
  .bus_idle_i  (bus_idle_i),
  .xfer_done_i (xfer_done_i),
  .ack_o       (ack_o),
  .gnt_o       (gnt_o),
  .gnt_ch_o    (gnt_ch_o),
  .cmd_o       (cmd_o)
);

// File: tb/test_dma_hs_arbiter_top.sv
module test_dma_hs_arbiter_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int SW  = 3;
  localparam int NP  = 16;
  localparam int STR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req = '0;
  logic [NCH-1:0] en = '0;
  logic [NCH*SW-1:0] sel = '0;
  logic          bus_idle = 1'b1;
  logic          done = 1'b0;
  logic [NCH-1:0] ack, conflict;
  logic          gnt, cmd;
  logic [2:0]    gnt_ch;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hs_arbiter_top i_dma_hs_arbiter_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ch_en_i(en), .ch_sel_i(sel),
    .bus_idle_i(bus_idle), .xfer_done_i(done), .ack_o(ack), .gnt_o(gnt),
    .gnt_ch_o(gnt_ch), .cmd_o(cmd), .conflict_o(conflict)
  );

  function automatic int phys(int c, int s);
    return (c * STR + s) % NP;
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic set_ch(int c, int s);
    sel[c*SW +: SW] = SW'(s);
    en[c] = 1'b1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cleanup();
    req = '0; done = 1'b1; bus_idle = 1'b1;
    step();
    done = 1'b0; en = '0; sel = '0;
    step(); step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R11", "ack", 32'(ack), 0);
    chk("R11", "gnt", 32'(gnt), 0);
    chk("R11", "gnt_ch", 32'(gnt_ch), 0);
    chk("R11", "cmd", 32'(cmd), 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_basic();
    set_ch(2, 3);
    req[phys(2, 3)] = 1'b1;
    step();
    chk("R2", "gnt", 32'(gnt), 1);
    chk("R2", "cmd", 32'(cmd), 1);
    chk("R2", "gnt_ch", 32'(gnt_ch), 2);
    chk("R1", "ack", 32'(ack), 32'h04);
    step();
    chk("R2", "cmd one cycle", 32'(cmd), 0);
    chk("R6", "gnt held", 32'(gnt), 1);
    chk("R4", "ack held", 32'(ack), 32'h04);
    req[phys(2, 3)] = 1'b0;
    step();
    chk("R4", "ack drop", 32'(ack), 0);
    chk("R6", "gnt before done", 32'(gnt), 1);
    done = 1'b1; step(); done = 1'b0;
    chk("R6", "gnt release", 32'(gnt), 0);
    done = 1'b1; step(); done = 1'b0;
    chk("R6", "done idle gnt", 32'(gnt), 0);
    chk("R6", "done idle cmd", 32'(cmd), 0);
    cleanup();
  endtask

  task automatic t_bus_busy();
    bus_idle = 1'b0;
    set_ch(4, 1);
    req[phys(4, 1)] = 1'b1;
    repeat (3) step();
    chk("R2", "busy gnt", 32'(gnt), 0);
    chk("R2", "busy ack", 32'(ack), 0);
    bus_idle = 1'b1;
    step();
    chk("R2", "idle gnt", 32'(gnt), 1);
    chk("R2", "idle gnt_ch", 32'(gnt_ch), 4);
    cleanup();
  endtask

  task automatic t_priority();
    set_ch(1, 0);
    set_ch(6, 2);
    req[phys(1, 0)] = 1'b1;
    req[phys(6, 2)] = 1'b1;
    step();
    chk("R3", "gnt_ch", 32'(gnt_ch), 1);
    chk("R12", "single ack", 32'(ack), 32'h02);
    done = 1'b1; step(); done = 1'b0;
    chk("R6", "gnt release", 32'(gnt), 0);
    step();
    chk("R5", "busy ch not regranted", 32'(gnt_ch), 6);
    chk("R5", "ack pair", 32'(ack), 32'h42);
    req[phys(1, 0)] = 1'b0;
    step();
    chk("R4", "ch1 ack drop", 32'(ack), 32'h40);
    done = 1'b1; step(); done = 1'b0;
    chk("R6", "gnt release 2", 32'(gnt), 0);
    req[phys(1, 0)] = 1'b1;
    step();
    chk("R5", "regrant gnt", 32'(gnt), 1);
    chk("R5", "regrant ch", 32'(gnt_ch), 1);
    chk("R5", "regrant ack", 32'(ack), 32'h42);
    cleanup();
  endtask

  task automatic t_disabled();
    sel[3*SW +: SW] = 3'd0;
    en[3] = 1'b0;
    req[phys(3, 0)] = 1'b1;
    repeat (4) step();
    chk("R7", "disabled ack", 32'(ack), 0);
    chk("R7", "disabled gnt", 32'(gnt), 0);
    cleanup();
  endtask

  task automatic t_disable_mid();
    set_ch(0, 2);
    req[phys(0, 2)] = 1'b1;
    step();
    chk("R8", "ack start", 32'(ack), 32'h01);
    en[0] = 1'b0;
    done = 1'b1; step(); done = 1'b0;
    chk("R8", "ack kept", 32'(ack), 32'h01);
    chk("R6", "gnt release", 32'(gnt), 0);
    req[phys(0, 2)] = 1'b0;
    step();
    chk("R8", "ack idle", 32'(ack), 0);
    req[phys(0, 2)] = 1'b1;
    repeat (3) step();
    chk("R8", "no rearm ack", 32'(ack), 0);
    chk("R8", "no rearm gnt", 32'(gnt), 0);
    cleanup();
  endtask

  task automatic t_conflict();
    set_ch(0, 5);
    set_ch(1, 0);
    set_ch(2, 1);
    #1;
    chk("R9", "conflict set", 32'(conflict), 32'h03);
    req[phys(0, 5)] = 1'b1;
    step();
    chk("R10", "winner ch", 32'(gnt_ch), 0);
    chk("R10", "winner ack", 32'(ack), 32'h01);
    done = 1'b1; step(); done = 1'b0;
    step();
    chk("R10", "loser gnt", 32'(gnt), 0);
    chk("R10", "loser ack", 32'(ack), 32'h01);
    en[0] = 1'b0;
    #1;
    chk("R9", "conflict clear", 32'(conflict), 0);
    step();
    chk("R10", "freed ch gnt", 32'(gnt), 1);
    chk("R10", "freed ch idx", 32'(gnt_ch), 1);
    cleanup();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bus_busy();
    t_priority();
    t_disabled();
    t_disable_mid();
    t_conflict();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule